// File: doc/BRIEF.md
# Property Buffer Tag Walker

This engine processes a property-style message buffer that sits in a word-addressed memory. It is given a byte address, for example one taken from a mailbox slot. The walker ignores the low four bits of that address. It reads the two-word header, which holds the size in bytes followed by the request code. It then steps through the chain of tags until it finds a tag identifier of zero.

Each tag is handed to an external agent over a valid/ready port. The port carries the identifier, the size of the value area, the request length, and the word address where the value area begins. The agent then returns a response length. The walker writes that length back into the tag's length word with the top bit set.

When the chain is finished, the header code word is overwritten with a success or error code. A one-cycle done pulse returns the aligned buffer address. The engine has a single memory port with one-cycle read latency, and it never has more than one access in flight.

Top module: `pbw_walker`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o`, `err_o`, `tag_valid_o`, `rsp_ready_o`, `mem_rd_o` and `mem_wr_o` are all 0.
- R2: A `start_i` pulse seen while idle raises `busy_o` on the next edge. `start_i` is ignored while busy. `busy_o` stays high until the done pulse. The low 4 bits of `base_addr_i` are ignored, and `ret_addr_o` gives the address with those bits cleared.
- R3: At most one memory access is in flight. A read strobe is never asserted in two consecutive cycles, is never followed directly by a write, and read and write are never asserted together. Read data arrives the cycle after the strobe.
- R4: The header is at word base+0 (size in bytes) and word base+1 (code). If the size is below 12 or the code is not 0, the buffer is rejected with an error.
- R5: Every tag has three header words: identifier, value-area size in bytes, and request length. The low 31 bits of the request length are presented together with value address = tag word + 3. `tag_valid_o` and the fields stay stable until `tag_ready_i` is accepted.
- R6: The next tag starts 3 + ceil(value size / 4) words after the current one.
- R7: The response length is written to tag word + 2 as bit 31 = 1, with bits 30:0 = min(response length, value-area size).
- R8: When a tag identifier equals 0, word base+1 is set to 0x80000000. `done_o` then pulses with `err_o` = 0.
- R9: The walk fails if any of the following holds, with limit = base + ceil(size / 4):
  - a tag starts at or past the limit;
  - a tag's end (start + 3 + value words) lies past the limit;
  - a value-area size exceeds `MAX_VAL_BYTES`.
  On failure, no further tag is offered, word base+1 is set to 0x80000001, and `done_o` pulses with `err_o` = 1.
- R10: `done_o` lasts exactly one cycle, with `busy_o` already low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (accepted only while idle) |
| base_addr_i | input | AW+2 | Byte address of the buffer |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Walk ended with error (valid with done_o) |
| ret_addr_o | output | AW+2 | Aligned buffer address returned at completion |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after strobe |
| tag_valid_o | output | 1 | Tag offered |
| tag_ready_i | input | 1 | Tag accepted |
| tag_id_o | output | 32 | Tag identifier |
| tag_bufsz_o | output | 32 | Value-area size in bytes |
| tag_reqlen_o | output | 32 | Request length (bit 31 cleared) |
| tag_val_addr_o | output | AW | Word address of the value area |
| rsp_ready_o | output | 1 | Waiting for a response length |
| rsp_valid_i | input | 1 | Response length valid |
| rsp_len_i | input | 31 | Response length in bytes |

## Verification
The bench aims at the following cases; the result of getting each one wrong is given for each:

- **Odd-byte value sizes.** A tag whose value size is not a multiple of four must round up to the next word. A walker that truncates the size would land on a value word and take it for the next tag.
- **Oversized responses.** A response longer than the value area must be clamped. Without the clamp, the length word would claim more bytes than the area holds.
- **Bounds failures.** Four separate buffers check the bounds rules:
  - a tag that runs past the declared size;
  - a chain with no terminator inside the size;
  - an oversized value area, reached after a good tag;
  - a malformed header.
  In each case the bench expects the error code in the header and no extra tag offers. A walker that skipped a check would read past the buffer, or offer a tag it had no right to present.
- **Start while busy.** A start pulse with another address arrives during a walk. It must not change the returned address or the memory contents.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam logic [31:0] CODE_OK   = 32'h8000_0000;
  localparam logic [31:0] CODE_ERR  = 32'h8000_0001;
  localparam logic [31:0] RESP_FLAG = 32'h8000_0000;
  localparam int unsigned MIN_BUF_BYTES = 12;
  localparam int unsigned TAG_HDR_WORDS = 3;
  localparam int unsigned HDR_WORDS = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RWAIT, ST_RCAP, ST_NEXT, ST_CHK, ST_OFFER, ST_ANSWER, ST_WWAIT
  } walk_st_t;

  typedef enum logic [2:0] {
    FD_SIZE, FD_CODE, FD_ID, FD_BSZ, FD_LEN
  } field_t;
endpackage

// File: rtl/pbw_bounds.sv
module pbw_bounds #(
  parameter int unsigned MAX_VAL_BYTES = 1024
) (
  input  logic [31:0] cur_i,
  input  logic [31:0] limit_i,
  input  logic [31:0] bsz_i,
  output logic [31:0] next_cur_o,
  output logic        overrun_o,
  output logic        too_big_o
);
  import pbw_pkg::*;
  logic [31:0] val_words;

  always_comb begin
    val_words  = (bsz_i >> 2) + {31'd0, |bsz_i[1:0]};
    next_cur_o = cur_i + TAG_HDR_WORDS + val_words;
    overrun_o  = next_cur_o > limit_i;
    too_big_o  = bsz_i > MAX_VAL_BYTES;
  end
endmodule

// File: rtl/pbw_rsp_fmt.sv
module pbw_rsp_fmt (
  input  logic [30:0] rsp_len_i,
  input  logic [31:0] bsz_i,
  output logic [31:0] word_o
);
  import pbw_pkg::*;
  logic [31:0] len_ext;

  always_comb begin
    len_ext = {1'b0, rsp_len_i};
    word_o  = RESP_FLAG | ((len_ext > bsz_i) ? bsz_i : len_ext);
  end
endmodule

// File: rtl/pbw_walker.sv
module pbw_walker #(
  parameter int unsigned AW            = 10,
  parameter int unsigned MAX_VAL_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW+1:0]     base_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [AW+1:0]     ret_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              tag_valid_o,
  input  logic              tag_ready_i,
  output logic [31:0]       tag_id_o,
  output logic [31:0]       tag_bufsz_o,
  output logic [31:0]       tag_reqlen_o,
  output logic [AW-1:0]     tag_val_addr_o,
  output logic              rsp_ready_o,
  input  logic              rsp_valid_i,
  input  logic [30:0]       rsp_len_i
);
  import pbw_pkg::*;

  localparam int unsigned BW = AW + 2;
  localparam logic [BW-1:0] ALIGN_MASK = ~BW'(15);

  walk_st_t    st;
  field_t      fd;
  logic [31:0] base_w, cur, limit, size_r, id_r, bsz_r;
  logic        closing;
  logic [BW-1:0] aligned_b;
  logic [31:0] next_cur, wb_word;
  logic        overrun, too_big;

  assign aligned_b = base_addr_i & ALIGN_MASK;

  pbw_bounds #(.MAX_VAL_BYTES(MAX_VAL_BYTES)) u_bounds (
    .cur_i(cur), .limit_i(limit), .bsz_i(bsz_r),
    .next_cur_o(next_cur), .overrun_o(overrun), .too_big_o(too_big)
  );

  pbw_rsp_fmt u_fmt (
    .rsp_len_i(rsp_len_i), .bsz_i(bsz_r), .word_o(wb_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fd <= FD_SIZE;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0; ret_addr_o <= '0;
      mem_rd_o <= 1'b0; mem_wr_o <= 1'b0; mem_addr_o <= '0; mem_wdata_o <= '0;
      tag_valid_o <= 1'b0; rsp_ready_o <= 1'b0;
      tag_id_o <= '0; tag_bufsz_o <= '0; tag_reqlen_o <= '0; tag_val_addr_o <= '0;
      base_w <= '0; cur <= '0; limit <= '0; size_r <= '0; id_r <= '0; bsz_r <= '0;
      closing <= 1'b0;
    end else begin
      mem_rd_o <= 1'b0;
      mem_wr_o <= 1'b0;
      done_o   <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          base_w     <= 32'(aligned_b >> 2);
          ret_addr_o <= aligned_b;
          busy_o     <= 1'b1;
          err_o      <= 1'b0;
          closing    <= 1'b0;
          mem_rd_o   <= 1'b1;
          mem_addr_o <= AW'(aligned_b >> 2);
          fd         <= FD_SIZE;
          st         <= ST_RWAIT;
        end
        ST_RWAIT: st <= ST_RCAP;
        ST_RCAP: begin
          case (fd)
            FD_SIZE: begin
              size_r     <= mem_rdata_i;
              limit      <= base_w + (mem_rdata_i >> 2) + {31'd0, |mem_rdata_i[1:0]};
              mem_rd_o   <= 1'b1;
              mem_addr_o <= AW'(base_w + 1);
              fd         <= FD_CODE;
              st         <= ST_RWAIT;
            end
            FD_CODE: begin
              if (size_r < MIN_BUF_BYTES || mem_rdata_i != 32'd0) begin
                mem_wr_o <= 1'b1; mem_addr_o <= AW'(base_w + 1);
                mem_wdata_o <= CODE_ERR; err_o <= 1'b1; closing <= 1'b1;
                st <= ST_WWAIT;
              end else begin
                cur <= base_w + HDR_WORDS;
                st  <= ST_NEXT;
              end
            end
            FD_ID: begin
              id_r <= mem_rdata_i;
              if (mem_rdata_i == 32'd0) begin
                mem_wr_o <= 1'b1; mem_addr_o <= AW'(base_w + 1);
                mem_wdata_o <= CODE_OK; closing <= 1'b1;
                st <= ST_WWAIT;
              end else begin
                mem_rd_o <= 1'b1; mem_addr_o <= AW'(cur + 1);
                fd <= FD_BSZ; st <= ST_RWAIT;
              end
            end
            FD_BSZ: begin
              bsz_r <= mem_rdata_i;
              st    <= ST_CHK;
            end
            default: begin
              tag_id_o       <= id_r;
              tag_bufsz_o    <= bsz_r;
              tag_reqlen_o   <= mem_rdata_i & ~RESP_FLAG;
              tag_val_addr_o <= AW'(cur + TAG_HDR_WORDS);
              tag_valid_o    <= 1'b1;
              st             <= ST_OFFER;
            end
          endcase
        end
        ST_NEXT: begin
          if (cur >= limit) begin
            mem_wr_o <= 1'b1; mem_addr_o <= AW'(base_w + 1);
            mem_wdata_o <= CODE_ERR; err_o <= 1'b1; closing <= 1'b1;
            st <= ST_WWAIT;
          end else begin
            mem_rd_o <= 1'b1; mem_addr_o <= AW'(cur);
            fd <= FD_ID; st <= ST_RWAIT;
          end
        end
        ST_CHK: begin
          if (too_big || overrun) begin
            mem_wr_o <= 1'b1; mem_addr_o <= AW'(base_w + 1);
            mem_wdata_o <= CODE_ERR; err_o <= 1'b1; closing <= 1'b1;
            st <= ST_WWAIT;
          end else begin
            mem_rd_o <= 1'b1; mem_addr_o <= AW'(cur + 2);
            fd <= FD_LEN; st <= ST_RWAIT;
          end
        end
        ST_OFFER: if (tag_ready_i) begin
          tag_valid_o <= 1'b0;
          rsp_ready_o <= 1'b1;
          st          <= ST_ANSWER;
        end
        ST_ANSWER: if (rsp_valid_i) begin
          rsp_ready_o <= 1'b0;
          mem_wr_o    <= 1'b1;
          mem_addr_o  <= AW'(cur + 2);
          mem_wdata_o <= wb_word;
          cur         <= next_cur;
          st          <= ST_WWAIT;
        end
        ST_WWAIT: begin
          if (closing) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_NEXT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Guards on the memory port and handshakes
  p_rd_single_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> (!mem_rd_o && !mem_wr_o));
  p_no_rd_wr_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));
  p_access_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o || mem_wr_o) |-> busy_o);
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !tag_valid_o && !rsp_ready_o));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_offer_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tag_valid_o && !tag_ready_i) |=>
      (tag_valid_o && $stable(tag_id_o) && $stable(tag_val_addr_o) && $stable(tag_bufsz_o)));
  p_wr_flag_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> mem_wdata_o[31]);
  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o && !closing) |-> ({1'b0, mem_wdata_o[30:0]} <= bsz_r));
endmodule

// File: tb/pbw_walker_tb_top.sv
module pbw_walker_tb_top;
  localparam int AW = 10;
  localparam int MAXV = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            start_i = 1'b0;
  logic [AW+1:0]   base_addr_i = '0;
  logic            busy_o, done_o, err_o;
  logic [AW+1:0]   ret_addr_o;
  logic            mem_rd_o, mem_wr_o;
  logic [AW-1:0]   mem_addr_o;
  logic [31:0]     mem_wdata_o;
  logic [31:0]     mem_rdata_i = '0;
  logic            tag_valid_o;
  logic            tag_ready_i = 1'b0;
  logic [31:0]     tag_id_o, tag_bufsz_o, tag_reqlen_o;
  logic [AW-1:0]   tag_val_addr_o;
  logic            rsp_ready_o;
  logic            rsp_valid_i = 1'b0;
  logic [30:0]     rsp_len_i = '0;

  pbw_walker #(.AW(AW), .MAX_VAL_BYTES(MAXV)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_addr_i(base_addr_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ret_addr_o(ret_addr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .tag_valid_o(tag_valid_o), .tag_ready_i(tag_ready_i), .tag_id_o(tag_id_o),
    .tag_bufsz_o(tag_bufsz_o), .tag_reqlen_o(tag_reqlen_o),
    .tag_val_addr_o(tag_val_addr_o), .rsp_ready_o(rsp_ready_o),
    .rsp_valid_i(rsp_valid_i), .rsp_len_i(rsp_len_i)
  );

  logic [31:0] mem  [0:(1<<AW)-1];
  logic [31:0] mref [0:(1<<AW)-1];

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  int checks = 0;
  int errors = 0;
  int pat [0:3] = '{3, 100, 7, 9};

  logic [31:0] q_id [$];
  logic [31:0] q_bsz [$];
  logic [31:0] q_len [$];
  int          q_va [$];
  bit          ex_err;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
  endtask

  // Behavioural reference: walks the buffer by the requirements
  task automatic model(input int b);
    int size, limit, cur, bsz, vw, k, r;
    for (int i = 0; i < (1<<AW); i++) mref[i] = mem[i];
    q_id.delete(); q_bsz.delete(); q_len.delete(); q_va.delete();
    ex_err = 0;
    size  = int'(mem[b]);
    limit = b + (size + 3) / 4;
    if (size < 12 || mem[b+1] != 0) begin            // R4
      ex_err = 1; mref[b+1] = 32'h8000_0001; return;
    end
    cur = b + 2; k = 0;
    forever begin
      if (cur >= limit) begin ex_err = 1; mref[b+1] = 32'h8000_0001; return; end   // R9
      if (mem[cur] == 0) begin mref[b+1] = 32'h8000_0000; return; end             // R8
      bsz = int'(mem[cur+1]);
      vw  = (bsz + 3) / 4;                                                         // R6
      if (bsz > MAXV || cur + 3 + vw > limit) begin
        ex_err = 1; mref[b+1] = 32'h8000_0001; return;
      end
      q_id.push_back(mem[cur]); q_bsz.push_back(mem[cur+1]);
      q_len.push_back(mem[cur+2] & 32'h7FFF_FFFF); q_va.push_back(cur + 3);
      r = pat[k];
      mref[cur+2] = 32'h8000_0000 | 32'((r < bsz) ? r : bsz);                      // R7
      k++;
      cur = cur + 3 + vw;
    end
  endtask

  task automatic run_case(input logic [AW+1:0] addr, input string name, input bit poke);
    int n, cyc, ntag, mism;
    logic [AW+1:0] al;
    al = addr & ~(AW+2)'(15);
    model(int'(al >> 2));
    ntag = q_id.size();
    @(negedge clk);
    start_i = 1'b1; base_addr_i = addr;
    @(negedge clk);
    start_i = 1'b0;
    n = 0; cyc = 0;
    forever begin
      if (done_o) break;
      cyc++;
      if (cyc > 3000) begin chk(1'b0, {"R2 watchdog ", name}, 0, 1); break; end
      chk(busy_o === 1'b1, {"R2 busy ", name}, busy_o, 1);
      if (poke && cyc == 4) begin start_i = 1'b1; base_addr_i = 12'h3C0; end
      else start_i = 1'b0;
      if (tag_valid_o && !tag_ready_i) begin
        if (n < ntag) begin
          chk(tag_id_o == q_id[n], {"R5 id ", name}, tag_id_o, q_id[n]);
          chk(tag_bufsz_o == q_bsz[n], {"R5 bsz ", name}, tag_bufsz_o, q_bsz[n]);
          chk(tag_reqlen_o == q_len[n], {"R5 len ", name}, tag_reqlen_o, q_len[n]);
          chk(int'(tag_val_addr_o) == q_va[n], {"R6 addr ", name}, tag_val_addr_o, q_va[n]);
        end else chk(1'b0, {"R9 extra tag ", name}, n, ntag);
        tag_ready_i = 1'b1;
      end else tag_ready_i = 1'b0;
      if (rsp_ready_o && !rsp_valid_i) begin
        rsp_valid_i = 1'b1; rsp_len_i = 31'(pat[n]); n++;
      end else rsp_valid_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0; tag_ready_i = 1'b0; rsp_valid_i = 1'b0;
    chk(err_o == ex_err, {"R8 R9 err ", name}, err_o, ex_err);
    chk(ret_addr_o == al, {"R2 ret ", name}, ret_addr_o, al);
    chk(!busy_o, {"R10 busy low ", name}, busy_o, 0);
    chk(n == ntag, {"R5 tag count ", name}, n, ntag);
    @(negedge clk);
    chk(!done_o, {"R10 pulse ", name}, done_o, 0);
    mism = 0;
    for (int i = 0; i < (1<<AW); i++) if (mem[i] !== mref[i]) mism++;
    chk(mism == 0, {"R7 R8 memory ", name}, mism, 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({busy_o, done_o, err_o, tag_valid_o, rsp_ready_o, mem_rd_o, mem_wr_o} == 7'd0,
        "R1 reset", {busy_o, done_o, err_o, tag_valid_o, rsp_ready_o, mem_rd_o, mem_wr_o}, 0);

    // two tags, odd value size, clamped response, unaligned start address
    clear_mem();
    mem[32'h40] = 52; mem[32'h41] = 0;
    mem[32'h42] = 32'h0003_0002; mem[32'h43] = 8; mem[32'h44] = 4; mem[32'h45] = 7;
    mem[32'h47] = 32'h0004_0005; mem[32'h48] = 6; mem[32'h49] = 32'h8000_0002;
    run_case(12'h10C, "two tags", 1'b0);

    clear_mem();
    mem[32'h80] = 12; mem[32'h81] = 0;
    run_case(12'h200, "empty list", 1'b0);

    clear_mem();
    mem[32'h90] = 32; mem[32'h91] = 5;
    run_case(12'h240, "bad code R4", 1'b0);

    clear_mem();
    mem[32'hA0] = 8; mem[32'hA1] = 0;
    run_case(12'h280, "short size R4", 1'b0);

    clear_mem();
    mem[32'hB0] = 64; mem[32'hB2] = 32'h11; mem[32'hB3] = 4; mem[32'hB4] = 4;
    mem[32'hB6] = 32'h22; mem[32'hB7] = 2000; mem[32'hB8] = 0;
    run_case(12'h2C0, "too big R9", 1'b0);

    clear_mem();
    mem[32'hC0] = 24; mem[32'hC2] = 32'h33; mem[32'hC3] = 8;
    run_case(12'h300, "overrun R9", 1'b0);

    clear_mem();
    mem[32'hD0] = 20; mem[32'hD2] = 32'h44; mem[32'hD3] = 0; mem[32'hD4] = 0;
    mem[32'hD5] = 32'h55;
    run_case(12'h340, "no terminator R9", 1'b0);

    // start while busy must be ignored
    clear_mem();
    mem[32'hE0] = 52;
    mem[32'hE2] = 32'h0003_0002; mem[32'hE3] = 8; mem[32'hE4] = 4;
    mem[32'hE7] = 32'h0004_0005; mem[32'hE8] = 6; mem[32'hE9] = 1;
    mem[32'hF0] = 12;
    run_case(12'h380, "restart ignored R2", 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 global watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule